// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a parameterised set of sources and offers one of them at a time to a processor core. Each source has a small configuration field that enables it and gives it one of four priority levels, 0 (lowest) to 3 (highest). A request is offered only when its level clears two thresholds. The first is the core's 2-bit mask. The second is the nesting rule, which combines the level the core reports as in service with the level the block records at each acknowledge.

Each offered request carries a vector number, equal to the source index, and a handler address. The address is normally the programmed vector base plus twice the vector number. Two fast slots can each be loaded with a vector number and a full handler address. A level-2 request whose vector matches a slot takes that slot's address instead, and the fast flag is raised.

The core takes the offered request with a one-cycle acknowledge. This clears the source's pending bit and pushes the matching in-service code onto an internal nesting stack. A one-cycle return pulse pops the stack.

Top module: `nest_irq_ctrl`

## Requirements
- R1: With no eligible request, `irq_valid_o`, `irq_vec_o`, `irq_lvl_o`, `irq_addr_o` and `irq_fast_o` are all zero. This holds from reset onward, and every configuration register resets to zero.
- R2: The priority field of source i is written at register address 8+i. Bit 2 enables the source and bits 1:0 give its level. A disabled source never latches a request, and disabling a pending source drops its request, so it is not offered again after it is re-enabled.
- R3: `core_mask_i` sets the lowest level that may be offered: 00 allows levels 0 to 3, 01 allows 1 to 3, 10 allows 2 to 3, and 11 allows only 3.
- R4: `act_lvl_i` sets a nesting threshold with the same encoding: 00 lets any level through, 01 needs level 1 or above, 10 needs level 2 or above, and 11 lets only level 3 through.
- R5: Among eligible pending requests, the highest level is offered. Ties go to the lowest source index, which is also the vector number.
- R6: For a request that is not fast, `irq_addr_o` = base + 2 × vector, kept to ADDR_W bits. The base register is at address 0.
- R7: A request is fast only when its level is 2 and its vector equals a fast-match register. Match 0 is at address 1 and match 1 at address 2. A fast request's address is {high, low} from that slot's address pair: slot 0 low/high at 3/4 and slot 1 low/high at 5/6, with 16 low bits. The vector base then has no effect.
- R8: When both fast-match registers hold the vector of an offered level-2 request, slot 0's address is used.
- R9: `ack_i` while a request is offered clears that source's pending bit. A new request from the same source in the same cycle keeps the bit set.
- R10: Acknowledge records an in-service code: 01 for level 0, 10 for level 1, and 11 for levels 2 and 3. This code limits eligibility the same way `act_lvl_i` does. `ret_i` restores the code that was in force before the last acknowledge, and from an empty stack it restores 00.
- R11: When acknowledge and return come in the same cycle, the current code is replaced by the new request's code and the older entries of the stack are left unchanged.
- R12: A one-cycle request pulse on an enabled source stays pending until that source is acknowledged or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | RA_W (4) | Configuration register address |
| wr_data | input | ADDR_W (21) | Configuration write data |
| req_i | input | NUM_SRC (8) | Request pulses, one per source |
| core_mask_i | input | 2 | Core interrupt mask |
| act_lvl_i | input | 2 | In-service level reported by the core |
| ack_i | input | 1 | Core takes the offered request |
| ret_i | input | 1 | Core returns from the current handler |
| irq_valid_o | output | 1 | A request is offered |
| irq_vec_o | output | VEC_W (3) | Vector number of the offered request |
| irq_lvl_o | output | 2 | Level of the offered request |
| irq_addr_o | output | ADDR_W (21) | Handler address |
| irq_fast_o | output | 1 | Offered request uses a fast slot |

## Verification
Two pairs of events can land in the same clock edge, and both are exercised on purpose. In the first pair, the bench raises an acknowledge of source 1 together with a fresh request pulse from source 1. It then returns and expects source 1 to be offered again, since setting the bit wins over clearing it. In the second pair, the bench raises acknowledge and return together while a level-1 handler sits in service below a level-3 one. After the next return it expects the level-1 source to be offered, which can happen only if the stack below the replaced code kept its saved 00 entry.

// File: rtl/nic_pkg.sv
package nic_pkg;

  typedef logic [1:0] lvl_t;

  // First configuration address used by the per-source priority fields
  localparam int unsigned PRIO_BASE_ADDR = 8;
  localparam int unsigned ADDR_LO_W      = 16;

  localparam logic [2:0] SEL_BASE  = 3'd0;
  localparam logic [2:0] SEL_FM0   = 3'd1;
  localparam logic [2:0] SEL_FM1   = 3'd2;
  localparam logic [2:0] SEL_F0_LO = 3'd3;
  localparam logic [2:0] SEL_F0_HI = 3'd4;
  localparam logic [2:0] SEL_F1_LO = 3'd5;
  localparam logic [2:0] SEL_F1_HI = 3'd6;

  function automatic lvl_t lvl_max(lvl_t a, lvl_t b);
    return (a > b) ? a : b;
  endfunction

  // In-service code recorded when a request of the given level is taken
  function automatic lvl_t lvl_to_code(lvl_t l);
    case (l)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
  import nic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 3,
  parameter int unsigned ADDR_W  = 21,
  parameter int unsigned RA_W    = 4,
  localparam int unsigned HI_W   = ADDR_W - ADDR_LO_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [RA_W-1:0]             wr_addr,
  input  logic [ADDR_W-1:0]           wr_data,
  output logic [ADDR_W-1:0]           base_o,
  output logic [VEC_W-1:0]            fm0_o,
  output logic [VEC_W-1:0]            fm1_o,
  output logic [ADDR_W-1:0]           fa0_o,
  output logic [ADDR_W-1:0]           fa1_o,
  output logic [NUM_SRC-1:0]          src_en_o,
  output logic [NUM_SRC-1:0][1:0]     src_lvl_o
);

  logic [ADDR_W-1:0]    base_q, base_d;
  logic [VEC_W-1:0]     fm0_q, fm0_d, fm1_q, fm1_d;
  logic [ADDR_LO_W-1:0] f0lo_q, f0lo_d, f1lo_q, f1lo_d;
  logic [HI_W-1:0]      f0hi_q, f0hi_d, f1hi_q, f1hi_d;
  logic                 glob_hit;

  assign glob_hit = wr_en && (wr_addr < RA_W'(PRIO_BASE_ADDR));

  always_comb begin
    base_d = base_q;
    fm0_d  = fm0_q;
    fm1_d  = fm1_q;
    f0lo_d = f0lo_q;
    f0hi_d = f0hi_q;
    f1lo_d = f1lo_q;
    f1hi_d = f1hi_q;
    if (glob_hit) begin
      case (wr_addr[2:0])
        SEL_BASE:  base_d = wr_data;
        SEL_FM0:   fm0_d  = wr_data[VEC_W-1:0];
        SEL_FM1:   fm1_d  = wr_data[VEC_W-1:0];
        SEL_F0_LO: f0lo_d = wr_data[ADDR_LO_W-1:0];
        SEL_F0_HI: f0hi_d = wr_data[ADDR_W-1:ADDR_LO_W];
        SEL_F1_LO: f1lo_d = wr_data[ADDR_LO_W-1:0];
        SEL_F1_HI: f1hi_d = wr_data[ADDR_W-1:ADDR_LO_W];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      fm0_q  <= '0;
      fm1_q  <= '0;
      f0lo_q <= '0;
      f0hi_q <= '0;
      f1lo_q <= '0;
      f1hi_q <= '0;
    end else begin
      base_q <= base_d;
      fm0_q  <= fm0_d;
      fm1_q  <= fm1_d;
      f0lo_q <= f0lo_d;
      f0hi_q <= f0hi_d;
      f1lo_q <= f1lo_d;
      f1hi_q <= f1hi_d;
    end
  end

  // One enable+level field per source
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_prio
    logic       hit;
    logic [2:0] fld_q, fld_d;

    assign hit   = wr_en && (wr_addr == RA_W'(PRIO_BASE_ADDR + gi));
    assign fld_d = hit ? wr_data[2:0] : fld_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fld_q <= '0;
      else        fld_q <= fld_d;
    end

    assign src_en_o[gi]  = fld_q[2];
    assign src_lvl_o[gi] = fld_q[1:0];
  end

  assign base_o = base_q;
  assign fm0_o  = fm0_q;
  assign fm1_o  = fm1_q;
  assign fa0_o  = {f0hi_q, f0lo_q};
  assign fa1_o  = {f1hi_q, f1lo_q};

endmodule

// File: rtl/nic_pending.sv
module nic_pending #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               clr_en_i,
  input  logic [VEC_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] pend_q, pend_d, clr_mask;

  always_comb begin
    clr_mask = clr_en_i ? (NUM_SRC'(1) << clr_idx_i) : '0;
    // a new request beats the clear; disabled sources hold nothing
    pend_d   = ((pend_q & ~clr_mask) | req_i) & src_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 3
) (
  input  logic [NUM_SRC-1:0]      cand_i,
  input  logic [NUM_SRC-1:0][1:0] lvl_i,
  input  lvl_t                    thr_i,
  output logic                    win_v_o,
  output logic [VEC_W-1:0]        win_idx_o,
  output lvl_t                    win_lvl_o
);

  // Scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    win_v_o   = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand_i[i] && (lvl_i[i] >= thr_i) &&
          (!win_v_o || (lvl_i[i] >= win_lvl_o))) begin
        win_v_o   = 1'b1;
        win_idx_o = VEC_W'(i);
        win_lvl_o = lvl_i[i];
      end
    end
  end

endmodule

// File: rtl/nic_nest_stack.sv
module nic_nest_stack
  import nic_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_t push_code_i,
  output lvl_t cur_code_o,
  output lvl_t saved0_o
);

  lvl_t             cur_q, cur_d;
  lvl_t [DEPTH-1:0] stk_q, stk_d;

  always_comb begin
    cur_d = cur_q;
    stk_d = stk_q;
    if (push_i && pop_i) begin
      cur_d = push_code_i;
    end else if (push_i) begin
      cur_d    = push_code_i;
      stk_d[0] = cur_q;
      for (int k = 1; k < DEPTH; k++) stk_d[k] = stk_q[k-1];
    end else if (pop_i) begin
      cur_d = stk_q[0];
      for (int k = 0; k < DEPTH - 1; k++) stk_d[k] = stk_q[k+1];
      stk_d[DEPTH-1] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      stk_q <= '0;
    end else begin
      cur_q <= cur_d;
      stk_q <= stk_d;
    end
  end

  assign cur_code_o = cur_q;
  assign saved0_o   = stk_q[0];

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned ADDR_W     = 21,
  parameter int unsigned NEST_DEPTH = 4,
  localparam int unsigned VEC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned RA_W  = $clog2(PRIO_BASE_ADDR + NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RA_W-1:0]    wr_addr,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [1:0]         core_mask_i,
  input  logic [1:0]         act_lvl_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               irq_valid_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic [1:0]         irq_lvl_o,
  output logic [ADDR_W-1:0]  irq_addr_o,
  output logic               irq_fast_o
);

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  logic [ADDR_W-1:0]      base_w, fa0_w, fa1_w;
  logic [VEC_W-1:0]       fm0_w, fm1_w;
  logic [NUM_SRC-1:0]     src_en_w, pend_w;
  logic [NUM_SRC-1:0][1:0] src_lvl_w;
  logic                   win_v;
  logic [VEC_W-1:0]       win_idx;
  lvl_t                   win_lvl, thr, cur_code_w, saved0_w;
  logic                   take, hit0, hit1;

  nic_cfg_regs #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .RA_W(RA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .base_o(base_w), .fm0_o(fm0_w), .fm1_o(fm1_w),
    .fa0_o(fa0_w), .fa1_o(fa1_w), .src_en_o(src_en_w), .src_lvl_o(src_lvl_w)
  );

  assign take = ack_i && win_v;

  nic_pending #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pend (
    .clk(clk), .rst_n(rst_q), .req_i(req_i), .src_en_i(src_en_w),
    .clr_en_i(take), .clr_idx_i(win_idx), .pend_o(pend_w)
  );

  // Both the core mask and the nesting level must be cleared
  assign thr = lvl_max(lvl_max(core_mask_i, act_lvl_i), cur_code_w);

  nic_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
    .cand_i(pend_w & src_en_w), .lvl_i(src_lvl_w), .thr_i(thr),
    .win_v_o(win_v), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  nic_nest_stack #(.DEPTH(NEST_DEPTH)) u_nest (
    .clk(clk), .rst_n(rst_q), .push_i(take), .pop_i(ret_i),
    .push_code_i(lvl_to_code(win_lvl)), .cur_code_o(cur_code_w),
    .saved0_o(saved0_w)
  );

  assign hit0 = (win_lvl == 2'd2) && (win_idx == fm0_w);
  assign hit1 = (win_lvl == 2'd2) && (win_idx == fm1_w);

  always_comb begin
    irq_valid_o = win_v;
    irq_vec_o   = '0;
    irq_lvl_o   = '0;
    irq_addr_o  = '0;
    irq_fast_o  = 1'b0;
    if (win_v) begin
      irq_vec_o  = win_idx;
      irq_lvl_o  = win_lvl;
      irq_fast_o = hit0 || hit1;
      if (hit0)      irq_addr_o = fa0_w;
      else if (hit1) irq_addr_o = fa1_w;
      else           irq_addr_o = base_w + ADDR_W'({win_idx, 1'b0});
    end
  end

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 3
) (
  input logic               clk,
  input logic               rst_q,
  input logic [NUM_SRC-1:0] req_i,
  input logic [1:0]         core_mask_i,
  input logic [1:0]         act_lvl_i,
  input logic               ack_i,
  input logic               ret_i,
  input logic               irq_valid_o,
  input logic [VEC_W-1:0]   irq_vec_o,
  input logic [1:0]         irq_lvl_o,
  input logic               irq_fast_o,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] src_en,
  input logic [1:0]         cur_code,
  input logic [1:0]         saved0
);

  p_enabled_only_r2: assert property (@(posedge clk) disable iff (!rst_q)
    irq_valid_o |-> src_en[irq_vec_o]);

  p_mask_floor_r3: assert property (@(posedge clk) disable iff (!rst_q)
    irq_valid_o |-> (irq_lvl_o >= core_mask_i));

  p_nest_floor_r4: assert property (@(posedge clk) disable iff (!rst_q)
    irq_valid_o |-> (irq_lvl_o >= act_lvl_i));

  p_stack_floor_r10: assert property (@(posedge clk) disable iff (!rst_q)
    irq_valid_o |-> (irq_lvl_o >= cur_code));

  p_fast_is_lvl2_r7: assert property (@(posedge clk) disable iff (!rst_q)
    irq_fast_o |-> (irq_valid_o && irq_lvl_o == 2'd2));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (ack_i && irq_valid_o && !req_i[irq_vec_o]) |=> !pend[$past(irq_vec_o)]);

  p_ret_restores_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (ret_i && !ack_i) |=> (cur_code == $past(saved0)));

  p_ackret_keeps_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (ack_i && ret_i && irq_valid_o) |=> (saved0 == $past(saved0)));

endmodule

bind nest_irq_ctrl nic_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .req_i(req_i), .core_mask_i(core_mask_i),
  .act_lvl_i(act_lvl_i), .ack_i(ack_i), .ret_i(ret_i),
  .irq_valid_o(irq_valid_o), .irq_vec_o(irq_vec_o), .irq_lvl_o(irq_lvl_o),
  .irq_fast_o(irq_fast_o), .pend(pend_w), .src_en(src_en_w),
  .cur_code(cur_code_w), .saved0(saved0_w)
);

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;

  localparam int NS = 8;
  localparam int AW = 21;
  localparam int VW = 3;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [RW-1:0] wr_addr = '0;
  logic [AW-1:0] wr_data = '0;
  logic [NS-1:0] req_i = '0;
  logic [1:0]    core_mask_i = '0;
  logic [1:0]    act_lvl_i = '0;
  logic          ack_i = 1'b0;
  logic          ret_i = 1'b0;
  logic          irq_valid_o;
  logic [VW-1:0] irq_vec_o;
  logic [1:0]    irq_lvl_o;
  logic [AW-1:0] irq_addr_o;
  logic          irq_fast_o;

  always #2 clk = ~clk;

  nest_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .req_i(req_i), .core_mask_i(core_mask_i),
    .act_lvl_i(act_lvl_i), .ack_i(ack_i), .ret_i(ret_i),
    .irq_valid_o(irq_valid_o), .irq_vec_o(irq_vec_o), .irq_lvl_o(irq_lvl_o),
    .irq_addr_o(irq_addr_o), .irq_fast_o(irq_fast_o)
  );

  typedef struct {
    int            rq;
    logic          v;
    logic [VW-1:0] vec;
    logic [1:0]    lvl;
    logic [AW-1:0] addr;
    logic          fast;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // Monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (irq_valid_o !== e.v || irq_vec_o !== e.vec || irq_lvl_o !== e.lvl ||
          irq_addr_o !== e.addr || irq_fast_o !== e.fast) begin
        n_fail++;
        $display("FAIL R%0d: got v=%b vec=%0d lvl=%0d addr=%h fast=%b, exp v=%b vec=%0d lvl=%0d addr=%h fast=%b",
                 e.rq, irq_valid_o, irq_vec_o, irq_lvl_o, irq_addr_o, irq_fast_o,
                 e.v, e.vec, e.lvl, e.addr, e.fast);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(int rq, logic v, int vec, int lvl, logic [AW-1:0] addr, logic fast);
    exp_t e;
    e.rq = rq; e.v = v; e.vec = VW'(vec); e.lvl = 2'(lvl); e.addr = addr; e.fast = fast;
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic expect_none(int rq);
    expect_out(rq, 1'b0, 0, 0, '0, 1'b0);
  endtask

  task automatic cfg(int a, logic [AW-1:0] d);
    wr_en = 1'b1; wr_addr = RW'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse_req(logic [NS-1:0] m);
    req_i = m;
    tick();
    req_i = '0;
  endtask

  task automatic do_ack(logic with_ret);
    ack_i = 1'b1; ret_i = with_ret;
    tick();
    ack_i = 1'b0; ret_i = 1'b0;
  endtask

  task automatic do_ret();
    ret_i = 1'b1;
    tick();
    ret_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    expect_none(1);                                   // R1 reset state

    pulse_req(8'h08);
    expect_none(2);                                   // R2 disabled source ignores request
    cfg(8 + 3, 21'h5);
    expect_none(2);                                   // R2 nothing latched while disabled

    cfg(0, 21'h01000);
    pulse_req(8'h08);
    expect_out(6, 1'b1, 3, 1, 21'h01006, 1'b0);       // R6 base + 2*vec
    tick();
    expect_out(12, 1'b1, 3, 1, 21'h01006, 1'b0);      // R12 pulse stays pending

    core_mask_i = 2'b10;
    expect_none(3);                                   // R3 mask 10 blocks level 1
    core_mask_i = 2'b01;
    expect_out(3, 1'b1, 3, 1, 21'h01006, 1'b0);       // R3 mask 01 lets level 1
    core_mask_i = 2'b00;
    act_lvl_i = 2'b10;
    expect_none(4);                                   // R4 active 10 needs level 2
    act_lvl_i = 2'b01;
    expect_out(4, 1'b1, 3, 1, 21'h01006, 1'b0);       // R4 active 01 lets level 1
    act_lvl_i = 2'b00;

    cfg(8 + 5, 21'h5);
    cfg(8 + 6, 21'h7);
    cfg(8 + 1, 21'h5);
    pulse_req(8'h22);
    expect_out(5, 1'b1, 1, 1, 21'h01002, 1'b0);       // R5 tie goes to lowest index
    pulse_req(8'h40);
    expect_out(5, 1'b1, 6, 3, 21'h0100C, 1'b0);       // R5 highest level wins

    do_ack(1'b0);
    expect_none(10);                                  // R10 code 11 blocks level 1
    do_ret();
    expect_out(10, 1'b1, 1, 1, 21'h01002, 1'b0);      // R10 return restores 00

    req_i = 8'h02; ack_i = 1'b1;
    tick();
    req_i = '0; ack_i = 1'b0;
    expect_none(10);                                  // R10 code 10 blocks level 1
    do_ret();
    expect_out(9, 1'b1, 1, 1, 21'h01002, 1'b0);       // R9 same-cycle request kept
    do_ack(1'b0);
    do_ret();
    expect_out(9, 1'b1, 3, 1, 21'h01006, 1'b0);       // R9 ack cleared source 1

    do_ack(1'b0);
    pulse_req(8'h40);
    expect_out(5, 1'b1, 6, 3, 21'h0100C, 1'b0);       // R5 level 3 nests over code 10
    do_ack(1'b1);
    expect_none(11);                                  // R11 code replaced by 11
    do_ret();
    expect_out(11, 1'b1, 5, 1, 21'h0100A, 1'b0);      // R11 older entry 00 kept

    cfg(1, 21'h4);
    cfg(3, 21'h02345);
    cfg(4, 21'h1A0000);
    cfg(8 + 4, 21'h6);
    pulse_req(8'h10);
    expect_out(7, 1'b1, 4, 2, 21'h1A2345, 1'b1);      // R7 fast slot 0 address
    do_ack(1'b0);
    do_ret();
    cfg(8 + 4, 21'h7);
    pulse_req(8'h10);
    expect_out(7, 1'b1, 4, 3, 21'h01008, 1'b0);       // R7 level 3 is not fast
    do_ack(1'b0);
    do_ret();

    cfg(2, 21'h4);
    cfg(5, 21'h00BCD);
    cfg(6, 21'h030000);
    cfg(8 + 4, 21'h6);
    pulse_req(8'h10);
    expect_out(8, 1'b1, 4, 2, 21'h1A2345, 1'b1);      // R8 slot 0 wins double match
    cfg(1, 21'h7);
    expect_out(8, 1'b1, 4, 2, 21'h030BCD, 1'b1);      // R8 slot 1 alone matches
    cfg(0, 21'h1FFFFE);
    expect_out(7, 1'b1, 4, 2, 21'h030BCD, 1'b1);      // R7 base has no effect on fast
    do_ack(1'b0);
    do_ret();
    expect_out(6, 1'b1, 5, 1, 21'h000008, 1'b0);      // R6 address wraps at 21 bits

    cfg(8 + 5, 21'h1);
    expect_none(2);                                   // R2 disabling drops request
    cfg(8 + 5, 21'h5);
    expect_none(2);                                   // R2 dropped request stays gone

    tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule